// File: doc/BRIEF.md
# Soft Reset Bus Controller

This block sits between a processor core and its system bus and carries out a logic-only reset of the bus interface. The clock keeps running throughout. An active-low soft reset request is sampled on each rising clock edge. For as long as it is sampled low, the block takes the bus for itself. It drives a fixed 9-bit command code, holds both active-low handshakes at their inactive level, and enables the address/data drivers with a don't-care fill.

On entry the block aborts any multicycle transfer that is in flight. It also counts how long the request stays low. When the request is released after a long enough pulse, the core receives a one-cycle request to start fetching at the reset exception vector. A pulse that is too short is discarded: the bus returns to the core, no vector request is made, and a one-cycle short-pulse flag is raised instead. The block clears nothing outside the bus path, so the core's own state stays available for inspection.

A separate synchronous active-high reset, `rst`, initialises the controller itself. While `rst` is high the soft reset input is ignored.

Top module: `softrst_bus_ctl`

## Requirements
- R1: Outside soft reset, each bus output (`bus_cmd`, `bus_ad`, `bus_ad_oe`, `bus_valid_n`, `bus_release_n`, `bus_own`) equals the matching core input sampled at the previous rising edge.
- R2: After each rising edge that samples `srst_n` low, `bus_cmd` is 9'b111010000 and `bus_own` is 1.
- R3: After each rising edge that samples `srst_n` low, `bus_valid_n` and `bus_release_n` are both 1.
- R4: After each rising edge that samples `srst_n` low, `bus_ad_oe` is 1 and `bus_ad` carries the fill value, which is all zeros by default.
- R5: `xfer_abort` is high for exactly one cycle after the first low-sampled edge of a pulse, and only if `xfer_busy` was high at that edge. It is low at all other times.
- R6: If `srst_n` was sampled low on at least MIN_CYCLES (16) consecutive edges, `vec_req` is high for exactly one cycle after the first edge that samples it high again.
- R7: A pulse shorter than MIN_CYCLES edges (15 is the boundary) produces no `vec_req`. Instead `short_err` is high for one cycle, in the same cycle `vec_req` would have used. The two are never high together.
- R8: The pulse-length count saturates, so a pulse of any length, for example 300 cycles, gives exactly one `vec_req`.
- R9: While `rst` is high, `srst_n` is ignored. One cycle after `rst` is sampled high, the outputs are idle: `bus_cmd`=0, `bus_ad`=0, `bus_ad_oe`=0, `bus_own`=0, `bus_valid_n`=1, `bus_release_n`=1, and all three pulses are 0.
- R10: A pulse that starts on the edge right after a release is counted from scratch, so two back-to-back 16-cycle pulses give two `vec_req` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high controller reset |
| srst_n | input | 1 | Soft reset request, active low, synchronous to clk |
| core_cmd | input | 9 | Command from core |
| core_ad | input | 64 | Address/data from core |
| core_ad_oe | input | 1 | Core address/data output enable |
| core_valid_n | input | 1 | Core valid-out, active low |
| core_release_n | input | 1 | Core bus release, active low |
| core_own | input | 1 | Core holds the bus |
| xfer_busy | input | 1 | A multicycle transfer is outstanding |
| bus_cmd | output | 9 | Registered bus command |
| bus_ad | output | 64 | Registered address/data |
| bus_ad_oe | output | 1 | Address/data output enable |
| bus_valid_n | output | 1 | Valid-out, active low |
| bus_release_n | output | 1 | Release, active low |
| bus_own | output | 1 | Bus ownership claim |
| xfer_abort | output | 1 | One-cycle abort of the in-flight transfer |
| vec_req | output | 1 | One-cycle reset-vector fetch request |
| short_err | output | 1 | One-cycle flag for a discarded short pulse |

## Verification
The properties assume that `srst_n` changes only between rising edges and is never metastable, because the block does no synchronisation of its own. They also assume the core inputs are stable around each edge. The stimulus changes every input on the falling edge, so each rising edge sees settled values. Pulse lengths are chosen on purpose: a short pulse, 15, exactly 16, 300, back-to-back 16-cycle pulses with a single high edge between them, and a pulse cut short by `rst`. This covers the qualification boundary and counter saturation without depending on arbitrary timing.

// File: rtl/softrst_pkg.sv
package softrst_pkg;
  localparam int unsigned CMD_W = 9;
  localparam logic [CMD_W-1:0] RST_CMD = 9'b111010000;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic             ad_oe;
    logic             valid_n;
    logic             release_n;
    logic             own;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_IDLE = '{cmd: '0, ad_oe: 1'b0, valid_n: 1'b1,
                                    release_n: 1'b1, own: 1'b0};
  localparam bus_ctl_t CTL_FORCED = '{cmd: RST_CMD, ad_oe: 1'b1, valid_n: 1'b1,
                                      release_n: 1'b1, own: 1'b1};
endpackage

// File: rtl/softrst_qualify.sv
module softrst_qualify #(
  parameter int unsigned MIN_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic srst_n,
  output logic hold,
  output logic entry,
  output logic rel_ok,
  output logic rel_short
);
  localparam int unsigned CNT_W = $clog2(MIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_CYCLES);

  logic             in_rst_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max    = (cnt_q == CNT_MAX);
  assign hold      = ~srst_n;
  assign entry     = ~srst_n & ~in_rst_q;
  assign rel_ok    = srst_n & in_rst_q & at_max;
  assign rel_short = srst_n & in_rst_q & ~at_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_rst_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!srst_n) begin
      in_rst_q <= 1'b1;
      if (!at_max) cnt_q <= cnt_q + 1'b1;
    end else begin
      in_rst_q <= 1'b0;
      cnt_q    <= '0;
    end
  end
endmodule

// File: rtl/softrst_drive.sv
module softrst_drive
  import softrst_pkg::*;
#(
  parameter int unsigned AD_W = 64,
  parameter logic [AD_W-1:0] AD_FILL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  bus_ctl_t        core_ctl,
  input  logic [AD_W-1:0] core_ad,
  output bus_ctl_t        bus_ctl,
  output logic [AD_W-1:0] bus_ad
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ctl <= CTL_IDLE;
      bus_ad  <= '0;
    end else if (hold) begin
      bus_ctl <= CTL_FORCED;
      bus_ad  <= AD_FILL;
    end else begin
      bus_ctl <= core_ctl;
      bus_ad  <= core_ad;
    end
  end
endmodule

// File: rtl/softrst_events.sv
module softrst_events (
  input  logic clk,
  input  logic rst,
  input  logic entry,
  input  logic busy,
  input  logic rel_ok,
  input  logic rel_short,
  output logic abort_p,
  output logic vec_p,
  output logic short_p
);
  always_ff @(posedge clk) begin
    if (rst) begin
      abort_p <= 1'b0;
      vec_p   <= 1'b0;
      short_p <= 1'b0;
    end else begin
      abort_p <= entry & busy;
      vec_p   <= rel_ok;
      short_p <= rel_short;
    end
  end
endmodule

// File: rtl/softrst_bus_ctl.sv
module softrst_bus_ctl
  import softrst_pkg::*;
#(
  parameter int unsigned MIN_CYCLES = 16,
  parameter int unsigned AD_W = 64,
  parameter logic [AD_W-1:0] AD_FILL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst_n,
  input  logic [CMD_W-1:0] core_cmd,
  input  logic [AD_W-1:0]  core_ad,
  input  logic             core_ad_oe,
  input  logic             core_valid_n,
  input  logic             core_release_n,
  input  logic             core_own,
  input  logic             xfer_busy,
  output logic [CMD_W-1:0] bus_cmd,
  output logic [AD_W-1:0]  bus_ad,
  output logic             bus_ad_oe,
  output logic             bus_valid_n,
  output logic             bus_release_n,
  output logic             bus_own,
  output logic             xfer_abort,
  output logic             vec_req,
  output logic             short_err
);
  logic     hold, entry, rel_ok, rel_short;
  bus_ctl_t core_ctl, out_ctl;

  assign core_ctl = '{cmd: core_cmd, ad_oe: core_ad_oe, valid_n: core_valid_n,
                      release_n: core_release_n, own: core_own};

  softrst_qualify #(.MIN_CYCLES(MIN_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .srst_n(srst_n),
    .hold(hold), .entry(entry), .rel_ok(rel_ok), .rel_short(rel_short)
  );

  softrst_drive #(.AD_W(AD_W), .AD_FILL(AD_FILL)) u_drive (
    .clk(clk), .rst(rst), .hold(hold),
    .core_ctl(core_ctl), .core_ad(core_ad),
    .bus_ctl(out_ctl), .bus_ad(bus_ad)
  );

  softrst_events u_evt (
    .clk(clk), .rst(rst), .entry(entry), .busy(xfer_busy),
    .rel_ok(rel_ok), .rel_short(rel_short),
    .abort_p(xfer_abort), .vec_p(vec_req), .short_p(short_err)
  );

  assign bus_cmd       = out_ctl.cmd;
  assign bus_ad_oe     = out_ctl.ad_oe;
  assign bus_valid_n   = out_ctl.valid_n;
  assign bus_release_n = out_ctl.release_n;
  assign bus_own       = out_ctl.own;
endmodule

// File: rtl/softrst_bus_ctl_chk.sv
module softrst_bus_ctl_chk #(
  parameter int unsigned MIN_CYCLES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       srst_n,
  input logic [8:0] bus_cmd,
  input logic       bus_ad_oe,
  input logic       bus_valid_n,
  input logic       bus_release_n,
  input logic       bus_own,
  input logic       xfer_abort,
  input logic       vec_req,
  input logic       short_err
);
  int run_len;
  int last_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len  <= 0;
      last_run <= 0;
    end else if (!srst_n) begin
      run_len <= run_len + 1;
    end else begin
      last_run <= run_len;
      run_len  <= 0;
    end
  end

  a_r2_cmd_forced: assert property (@(posedge clk) disable iff (rst)
    !srst_n |=> (bus_cmd == 9'b111010000) && bus_own);
  a_r3_handshake_idle: assert property (@(posedge clk) disable iff (rst)
    !srst_n |=> bus_valid_n && bus_release_n);
  a_r4_ad_driven: assert property (@(posedge clk) disable iff (rst)
    !srst_n |=> bus_ad_oe);
  a_r5_abort_single: assert property (@(posedge clk) disable iff (rst)
    xfer_abort |=> !xfer_abort);
  a_r6_vec_single: assert property (@(posedge clk) disable iff (rst)
    vec_req |=> !vec_req);
  a_r6_vec_after_release: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> $past(srst_n) && !$past(srst_n, 2));
  a_r8_vec_long_enough: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> last_run >= int'(MIN_CYCLES));
  a_r7_short_len: assert property (@(posedge clk) disable iff (rst)
    short_err |-> (last_run > 0) && (last_run < int'(MIN_CYCLES)));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(vec_req && short_err));
endmodule

bind softrst_bus_ctl softrst_bus_ctl_chk #(.MIN_CYCLES(MIN_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .srst_n(srst_n), .bus_cmd(bus_cmd),
  .bus_ad_oe(bus_ad_oe), .bus_valid_n(bus_valid_n),
  .bus_release_n(bus_release_n), .bus_own(bus_own),
  .xfer_abort(xfer_abort), .vec_req(vec_req), .short_err(short_err)
);

// File: tb/softrst_bus_ctl_bench.sv
`timescale 1ns/1ps
module softrst_bus_ctl_bench;
  localparam int MIN = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        srst_n = 1'b0;
  logic [8:0]  core_cmd = '0;
  logic [63:0] core_ad = '0;
  logic        core_ad_oe = 1'b0, core_valid_n = 1'b1, core_release_n = 1'b1;
  logic        core_own = 1'b0, xfer_busy = 1'b0;
  logic [8:0]  bus_cmd;
  logic [63:0] bus_ad;
  logic        bus_ad_oe, bus_valid_n, bus_release_n, bus_own;
  logic        xfer_abort, vec_req, short_err;

  always #10 clk = ~clk;

  softrst_bus_ctl u_softrst_bus_ctl (
    .clk(clk), .rst(rst), .srst_n(srst_n),
    .core_cmd(core_cmd), .core_ad(core_ad), .core_ad_oe(core_ad_oe),
    .core_valid_n(core_valid_n), .core_release_n(core_release_n),
    .core_own(core_own), .xfer_busy(xfer_busy),
    .bus_cmd(bus_cmd), .bus_ad(bus_ad), .bus_ad_oe(bus_ad_oe),
    .bus_valid_n(bus_valid_n), .bus_release_n(bus_release_n),
    .bus_own(bus_own), .xfer_abort(xfer_abort), .vec_req(vec_req),
    .short_err(short_err)
  );

  int checks = 0, fails = 0;
  int vec_seen = 0, short_seen = 0, abort_seen = 0;
  bit started = 0;

  // behavioural reference state
  int          m_len = 0;
  bit          m_in = 0, m_forced = 0;
  logic [8:0]  e_cmd = '0;
  logic [63:0] e_ad = '0;
  logic        e_oe = 0, e_vn = 1, e_rn = 1, e_own = 0;
  logic        e_abort = 0, e_vec = 0, e_short = 0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      e_cmd = '0; e_ad = '0; e_oe = 0; e_vn = 1; e_rn = 1; e_own = 0;
      e_abort = 0; e_vec = 0; e_short = 0; m_len = 0; m_in = 0; m_forced = 0;
    end else begin
      e_abort = !srst_n && !m_in && xfer_busy;
      e_vec   = srst_n && m_in && (m_len >= MIN);
      e_short = srst_n && m_in && (m_len < MIN);
      if (!srst_n) begin
        m_forced = 1; m_in = 1; m_len++;
        e_cmd = 9'b111010000; e_ad = '0; e_oe = 1; e_vn = 1; e_rn = 1; e_own = 1;
      end else begin
        m_forced = 0; m_in = 0; m_len = 0;
        e_cmd = core_cmd; e_ad = core_ad; e_oe = core_ad_oe;
        e_vn = core_valid_n; e_rn = core_release_n; e_own = core_own;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(m_forced ? "R2 cmd" : "R1 cmd", 64'(bus_cmd), 64'(e_cmd));
      chk(m_forced ? "R2 own" : "R1 own", 64'(bus_own), 64'(e_own));
      chk(m_forced ? "R3 valid_n" : "R1 valid_n", 64'(bus_valid_n), 64'(e_vn));
      chk(m_forced ? "R3 release_n" : "R1 release_n", 64'(bus_release_n), 64'(e_rn));
      chk(m_forced ? "R4 ad" : "R1 ad", bus_ad, e_ad);
      chk(m_forced ? "R4 ad_oe" : "R1 ad_oe", 64'(bus_ad_oe), 64'(e_oe));
      chk("R5 abort", 64'(xfer_abort), 64'(e_abort));
      chk("R6 vec_req", 64'(vec_req), 64'(e_vec));
      chk("R7 short_err", 64'(short_err), 64'(e_short));
      if (vec_req) vec_seen++;
      if (short_err) short_seen++;
      if (xfer_abort) abort_seen++;
    end
  end

  task automatic traffic(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      core_cmd = 9'($urandom); core_ad = {$urandom, $urandom};
      core_ad_oe = 1'($urandom); core_valid_n = 1'($urandom);
      core_release_n = 1'($urandom); core_own = 1'($urandom);
    end
  endtask

  task automatic pulse(input int len, input bit busy);
    @(negedge clk); srst_n = 0; xfer_busy = busy;
    for (int i = 1; i < len; i++) begin
      @(negedge clk); xfer_busy = 1'($urandom); core_cmd = 9'($urandom);
    end
    @(negedge clk); srst_n = 1; xfer_busy = 0;
  endtask

  task automatic count_chk(input string req, input int act, input int exp);
    chk(req, 64'(act), 64'(exp));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9: srst_n low is ignored while rst is high
    repeat (3) @(negedge clk);
    count_chk("R9 reset cmd", int'(bus_cmd), 0);
    count_chk("R9 reset own", int'(bus_own), 0);
    srst_n = 1;
    @(negedge clk); rst = 0;
    traffic(20);                                   // R1
    pulse(5, 1'b1);                                // R5, R7 short
    traffic(3);
    count_chk("R7 short count", short_seen, 1);
    count_chk("R5 abort count", abort_seen, 1);
    pulse(MIN, 1'b0);                              // R6 exact boundary
    traffic(3);
    count_chk("R6 vec count", vec_seen, 1);
    pulse(MIN - 1, 1'b1);                          // R7 boundary 15
    traffic(3);
    count_chk("R7 vec after 15", vec_seen, 1);
    count_chk("R7 short after 15", short_seen, 2);
    pulse(300, 1'b0);                              // R8 saturation
    traffic(3);
    count_chk("R8 one vec for long pulse", vec_seen, 2);
    pulse(MIN, 1'b1);                              // R10 back-to-back
    pulse(MIN, 1'b1);
    traffic(3);
    count_chk("R10 two vec back-to-back", vec_seen, 4);
    // R9: rst during a pulse cancels it
    @(negedge clk); srst_n = 0;
    repeat (20) @(negedge clk);
    rst = 1;
    @(negedge clk);
    count_chk("R9 mid-pulse cmd", int'(bus_cmd), 0);
    count_chk("R9 mid-pulse own", int'(bus_own), 0);
    srst_n = 1;
    @(negedge clk); rst = 0;
    traffic(4);
    count_chk("R9 no vec after rst", vec_seen, 4);
    finish_run();
  end
endmodule